// File: doc/BRIEF.md
# PLL1 Frequency Profile Selector

This block keeps an eight-entry table of profiles for the first PLL and picks the live entry from three select pins. Each profile carries a reference divider, a feedback divider with a half-step bit, a loop-filter code, an enable for the PLL and a choice between two banks of output dividers. The row index is formed as `{S2, S1, S0}`. The two low pins are sampled only while reset is held, and they stay frozen from the moment reset is released. The top pin is followed at all times, so the system can switch between two profiles while it runs.

The selected profile is presented as registered outputs. The feedback and reference values are already expanded into the effective counts that the PLL consumes. The table is loaded through a byte-wide write port that uses the same address window as the device's register space.

The block also decides which clock outputs may drive. An output whose source code points at either phase of PLL1 is held off while the active profile has the PLL disabled. A shutdown/output-enable pin is decoded under a mode bit. In one mode the pin is a full shutdown, and in the other it only gates the outputs.

Top module: `pll_profile_sel`

## Requirements
- R1: While `rst` is high, every table entry clears to zero. After reset, before any write, the outputs show `fb_count`=6, `ref_count`=2, `lf_code`=0, `div_bank`=0 and `pll1_en`=0, and every output sourced from PLL1 is off.
- R2: The pins `sel_s1` and `sel_s0` are captured on every clock edge while `rst` is high. After reset falls, the captured values are held no matter how the pins move.
- R3: The active row is `{sel_s2, captured s1, captured s0}`, and `row_idx` shows it. `sel_s2` is followed live. The profile outputs take the new row's values on the first clock edge after the index changes and not before.
- R4: Row r occupies addresses 40h+3r to 40h+3r+2. The first byte is Q[7:0] and the second is P[7:0]. The third byte is the control byte: bit 7 is the bank select, bit 6 is the PLL1 enable, bits 5:3 are the loop-filter code, bit 2 is P0, and bits 1:0 are P[9:8].
- R5: `fb_count` = 2×(P+3)+P0 and `ref_count` = Q+2 for the active row. The extremes P=1023, P0=1, Q=255 give 2053 and 257.
- R6: A write to an address outside 40h..57h changes no table entry.
- R7: When the active row's PLL1 enable is 0, every output whose 3-bit source code is 010 or 011 is forced off. Outputs with other source codes are not affected.
- R8: With `pdn_mode`=1 and `oe_pin`=0, all `out_en` bits are 0, `pll_run`=0 and `pll1_en`=0.
- R9: With `pdn_mode`=0 and `oe_pin`=0, all `out_en` bits are 0, but `pll_run` stays 1 and `pll1_en` follows the row.
- R10: With `oe_pin`=1 and no PLL1 gating, each `out_en` bit equals its `out_req` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the capture window for the low select pins |
| wr_en | input | 1 | Table byte write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| sel_s0 | input | 1 | Select pin, index bit 0 (captured in reset) |
| sel_s1 | input | 1 | Select pin, index bit 1 (captured in reset) |
| sel_s2 | input | 1 | Select pin, index bit 2 (live) |
| oe_pin | input | 1 | Shutdown / output-enable pin |
| pdn_mode | input | 1 | 1: pin low means shutdown; 0: pin low only disables outputs |
| out_src | input | 12 | Per-output 3-bit source code, output i at bits 3i+2:3i |
| out_req | input | 4 | Per-output requested enable |
| fb_count | output | 12 | Effective feedback count of the active row |
| ref_count | output | 9 | Effective reference count of the active row |
| lf_code | output | 3 | Loop-filter code of the active row |
| pll1_en | output | 1 | PLL1 running (row enable and not shut down) |
| div_bank | output | 1 | Output divider bank select of the active row |
| out_en | output | 4 | Gated per-output enables |
| pll_run | output | 1 | PLLs powered (low in shutdown) |
| row_idx | output | 3 | Current row index |

## Verification
The PLL1 gating and the pin decode act on the same enable bits in the same cycle. A live change of the top select pin can therefore move into a disabled row while the shutdown pin is also low. The bench switches `sel_s2` between a row with PLL1 disabled and one with it enabled, using mixed source codes. It then drops `oe_pin` under both modes. Each resulting `out_en` vector is compared with the vector expected from the rules, so that a disabled row and a gated pin each yield off, and `pll_run` is judged separately from the outputs.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int Q_W       = 8;
    localparam int P_W       = 10;
    localparam int LF_W      = 3;
    localparam int ROWS      = 8;
    localparam int ROW_BYTES = 3;
    localparam int SRC_W     = 3;
    localparam int ADDR_W    = 8;
    localparam int IDX_W     = $clog2(ROWS);
    localparam int LATCH_W   = IDX_W - 1;
    localparam int PT_W      = P_W + 2;
    localparam int QT_W      = Q_W + 1;

    localparam logic [ADDR_W-1:0] TABLE_BASE   = 8'h40;
    localparam logic [SRC_W-1:0]  SRC_PLL1_POS = 3'b010;
    localparam logic [SRC_W-1:0]  SRC_PLL1_NEG = 3'b011;

    typedef enum logic [1:0] {
        BYTE_REFDIV = 2'd0,
        BYTE_FBLOW  = 2'd1,
        BYTE_CTRL   = 2'd2
    } row_byte_e;

    typedef struct packed {
        logic            bank;
        logic            en;
        logic [LF_W-1:0] lf;
        logic            p0;
        logic [P_W-1:0]  p;
        logic [Q_W-1:0]  q;
    } prof_row_t;

    function automatic logic [PT_W-1:0] feedback_count(logic [P_W-1:0] p, logic p0);
        logic [PT_W-1:0] t;
        t = PT_W'(p) + PT_W'(3);
        return (t << 1) | PT_W'(p0);
    endfunction

    function automatic logic [QT_W-1:0] reference_count(logic [Q_W-1:0] q);
        return QT_W'(q) + QT_W'(2);
    endfunction

    function automatic logic sources_pll1(logic [SRC_W-1:0] code);
        return (code == SRC_PLL1_POS) || (code == SRC_PLL1_NEG);
    endfunction

endpackage

// File: rtl/pps_table.sv
module pps_table
    import pps_pkg::*;
#(
    parameter int N_ROWS = ROWS,
    parameter logic [ADDR_W-1:0] BASE = TABLE_BASE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output prof_row_t [N_ROWS-1:0]  rows_o
);

    localparam int SPAN = N_ROWS * ROW_BYTES;

    prof_row_t [N_ROWS-1:0] rows;
    logic [ADDR_W-1:0]      off;
    logic                   in_range;

    assign off      = wr_addr - BASE;
    assign in_range = (wr_addr >= BASE) && ({1'b0, off} < (ADDR_W+1)'(SPAN));

    always_ff @(posedge clk) begin
        if (rst) begin
            rows <= '0;
        end else if (wr_en && in_range) begin
            for (int r = 0; r < N_ROWS; r++) begin
                if (off == ADDR_W'(r * ROW_BYTES + int'(BYTE_REFDIV)))
                    rows[r].q <= wr_data;
                if (off == ADDR_W'(r * ROW_BYTES + int'(BYTE_FBLOW)))
                    rows[r].p[7:0] <= wr_data;
                if (off == ADDR_W'(r * ROW_BYTES + int'(BYTE_CTRL))) begin
                    rows[r].bank    <= wr_data[7];
                    rows[r].en      <= wr_data[6];
                    rows[r].lf      <= wr_data[5:3];
                    rows[r].p0      <= wr_data[2];
                    rows[r].p[9:8]  <= wr_data[1:0];
                end
            end
        end
    end

    assign rows_o = rows;

    // R6: writes outside the window leave the table untouched
    p_oor_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> $stable(rows));

endmodule

// File: rtl/pps_index.sv
module pps_index
    import pps_pkg::*;
#(
    parameter int W_LATCH = LATCH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W_LATCH-1:0] pins_lo,
    input  logic               pin_hi,
    output logic [W_LATCH:0]   idx
);

    logic [W_LATCH-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) lo_q <= pins_lo;
    end

    assign idx = {pin_hi, lo_q};

    // R2: captured low bits never move outside reset
    p_lo_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(lo_q));

endmodule

// File: rtl/pps_gate.sv
module pps_gate
    import pps_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_OUT*SRC_W-1:0] src_codes,
    input  logic [N_OUT-1:0]       req,
    input  logic                   oe_pin,
    input  logic                   pdn_mode,
    input  logic                   row_en,
    output logic [N_OUT-1:0]       out_en,
    output logic                   pll_run
);

    assign pll_run = !(pdn_mode && !oe_pin);

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        logic from_pll1;
        assign from_pll1 = sources_pll1(src_codes[g*SRC_W +: SRC_W]);
        assign out_en[g] = req[g] && oe_pin && !(from_pll1 && !row_en);

        // R7: a disabled PLL1 never drives an output
        p_pll1_gate_r7: assert property (@(posedge clk) disable iff (rst)
            (!row_en && from_pll1) |-> !out_en[g]);
    end

    // R8: shutdown mode with pin low stops PLLs and outputs
    p_shutdown_r8: assert property (@(posedge clk) disable iff (rst)
        (pdn_mode && !oe_pin) |-> (!pll_run && out_en == '0));

    // R9: output-enable mode never stops the PLLs
    p_oe_only_r9: assert property (@(posedge clk) disable iff (rst)
        !pdn_mode |-> pll_run);

endmodule

// File: rtl/pll_profile_sel.sv
module pll_profile_sel
    import pps_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [7:0]               wr_addr,
    input  logic [7:0]               wr_data,
    input  logic                     sel_s0,
    input  logic                     sel_s1,
    input  logic                     sel_s2,
    input  logic                     oe_pin,
    input  logic                     pdn_mode,
    input  logic [NUM_OUT*3-1:0]     out_src,
    input  logic [NUM_OUT-1:0]       out_req,
    output logic [11:0]              fb_count,
    output logic [8:0]               ref_count,
    output logic [2:0]               lf_code,
    output logic                     pll1_en,
    output logic                     div_bank,
    output logic [NUM_OUT-1:0]       out_en,
    output logic                     pll_run,
    output logic [2:0]               row_idx
);

    prof_row_t [ROWS-1:0] rows;
    logic [IDX_W-1:0]     idx;
    prof_row_t            cur;
    logic                 en_q;

    pps_table #(.N_ROWS(ROWS), .BASE(TABLE_BASE)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rows_o  (rows)
    );

    pps_index #(.W_LATCH(LATCH_W)) u_index (
        .clk     (clk),
        .rst     (rst),
        .pins_lo ({sel_s1, sel_s0}),
        .pin_hi  (sel_s2),
        .idx     (idx)
    );

    assign cur = rows[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_count  <= feedback_count('0, 1'b0);
            ref_count <= reference_count('0);
            lf_code   <= '0;
            en_q      <= 1'b0;
            div_bank  <= 1'b0;
        end else begin
            fb_count  <= feedback_count(cur.p, cur.p0);
            ref_count <= reference_count(cur.q);
            lf_code   <= cur.lf;
            en_q      <= cur.en;
            div_bank  <= cur.bank;
        end
    end

    pps_gate #(.N_OUT(NUM_OUT)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .src_codes (out_src),
        .req       (out_req),
        .oe_pin    (oe_pin),
        .pdn_mode  (pdn_mode),
        .row_en    (en_q),
        .out_en    (out_en),
        .pll_run   (pll_run)
    );

    assign pll1_en = en_q && pll_run;
    assign row_idx = idx;

    // R5: effective counts never drop below their zero-setting floor
    p_count_floor_r5: assert property (@(posedge clk) disable iff (rst)
        (fb_count >= 12'd6) && (ref_count >= 9'd2));

    // R8: a shut-down part reports PLL1 stopped
    p_pll1_stop_r8: assert property (@(posedge clk) disable iff (rst)
        !pll_run |-> !pll1_en);

endmodule

// File: tb/tb_pll_profile_sel.sv
`timescale 1ns/1ps
module tb_pll_profile_sel;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = 0, wr_data = 0;
    logic        sel_s0 = 0, sel_s1 = 0, sel_s2 = 0;
    logic        oe_pin = 1, pdn_mode = 1;
    logic [11:0] out_src = {4{3'b010}};
    logic [3:0]  out_req = 4'hF;
    logic [11:0] fb_count;
    logic [8:0]  ref_count;
    logic [2:0]  lf_code, row_idx;
    logic        pll1_en, div_bank, pll_run;
    logic [3:0]  out_en;

    int checks = 0, fails = 0;
    bit finished = 0;

    int e_q[8], e_p[8], e_p0[8], e_lf[8], e_en[8], e_bank[8];

    always #4 clk = ~clk;

    pll_profile_sel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_s0(sel_s0), .sel_s1(sel_s1), .sel_s2(sel_s2),
        .oe_pin(oe_pin), .pdn_mode(pdn_mode), .out_src(out_src), .out_req(out_req),
        .fb_count(fb_count), .ref_count(ref_count), .lf_code(lf_code),
        .pll1_en(pll1_en), .div_bank(div_bank), .out_en(out_en),
        .pll_run(pll_run), .row_idx(row_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit s1, input bit s0);
        @(negedge clk);
        rst = 1; sel_s1 = s1; sel_s0 = s0;
        repeat (3) tick();
        rst = 0;
        tick();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 8'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic fill_expect();
        for (int r = 0; r < 8; r++) begin
            e_q[r]    = (r * 29 + 5) & 255;
            e_p[r]    = (r * 97 + 200) & 1023;
            e_p0[r]   = r & 1;
            e_lf[r]   = r & 7;
            e_en[r]   = (r != 3 && r != 5) ? 1 : 0;
            e_bank[r] = (r >> 1) & 1;
        end
        e_q[7] = 255; e_p[7] = 1023; e_p0[7] = 1;
    endtask

    // R4: byte layout of one row
    task automatic write_row(input int r);
        int ctl;
        ctl = (e_bank[r] << 7) | (e_en[r] << 6) | (e_lf[r] << 3) |
              (e_p0[r] << 2) | ((e_p[r] >> 8) & 3);
        wr(8'h40 + 3 * r, e_q[r]);
        wr(8'h40 + 3 * r + 1, e_p[r] & 255);
        wr(8'h40 + 3 * r + 2, ctl);
    endtask

    task automatic check_row(input int r, input string req);
        int efb, eref;
        efb  = 2 * (e_p[r] + 3) + e_p0[r];
        eref = e_q[r] + 2;
        chk(int'(fb_count) == efb, req, "fb_count", int'(fb_count), efb);
        chk(int'(ref_count) == eref, req, "ref_count", int'(ref_count), eref);
        chk(int'(lf_code) == e_lf[r], req, "lf_code", int'(lf_code), e_lf[r]);
        chk(int'(pll1_en) == e_en[r], req, "pll1_en", int'(pll1_en), e_en[r]);
        chk(int'(div_bank) == e_bank[r], req, "div_bank", int'(div_bank), e_bank[r]);
    endtask

    task automatic check_cleared(input string req);
        chk(fb_count == 12'd6, req, "fb_count cleared", int'(fb_count), 6);
        chk(ref_count == 9'd2, req, "ref_count cleared", int'(ref_count), 2);
        chk(lf_code == 3'd0, req, "lf_code cleared", int'(lf_code), 0);
        chk(pll1_en == 1'b0, req, "pll1_en cleared", int'(pll1_en), 0);
        chk(div_bank == 1'b0, req, "div_bank cleared", int'(div_bank), 0);
        chk(out_en == 4'h0, req, "pll1 outputs off", int'(out_en), 0);
    endtask

    task automatic t_reset();
        do_reset(0, 0);
        check_cleared("R1");
    endtask

    task automatic t_load();
        for (int r = 0; r < 8; r++) write_row(r);
        sel_s2 = 0;
        tick();
        chk(row_idx == 3'd0, "R3", "row_idx", int'(row_idx), 0);
        check_row(0, "R4/R5 row0");
        sel_s2 = 1;
        #1;
        chk(row_idx == 3'd4, "R3", "row_idx live", int'(row_idx), 4);
        check_row(0, "R3 before edge");
        tick();
        check_row(4, "R3 after edge");
    endtask

    task automatic t_hold();
        sel_s1 = 1; sel_s0 = 1;
        tick(); tick();
        chk(row_idx == 3'd4, "R2", "row_idx held", int'(row_idx), 4);
        check_row(4, "R2 held");
    endtask

    task automatic t_ignore();
        wr(8'h3F, 8'hFF);
        wr(8'h58, 8'hFF);
        wr(8'hFF, 8'hFF);
        tick();
        check_row(4, "R6 row4");
        sel_s2 = 0;
        tick();
        check_row(0, "R6 row0");
    endtask

    task automatic t_relatch();
        do_reset(1, 1);
        chk(row_idx == 3'd3, "R2", "row_idx relatched", int'(row_idx), 3);
        check_cleared("R1 after relatch");
        sel_s1 = 0; sel_s0 = 0;
        write_row(3);
        write_row(7);
        tick();
        chk(row_idx == 3'd3, "R2", "row_idx held", int'(row_idx), 3);
        check_row(3, "R4 row3");
        sel_s2 = 1;
        tick();
        chk(row_idx == 3'd7, "R3", "row_idx", int'(row_idx), 7);
        check_row(7, "R5 extremes");
    endtask

    task automatic t_gate();
        out_src = {3'b100, 3'b000, 3'b011, 3'b010};
        out_req = 4'hF;
        sel_s2 = 0;
        tick();
        chk(out_en == 4'b1100, "R7", "disabled row", int'(out_en), 12);
        sel_s2 = 1;
        tick();
        chk(out_en == 4'b1111, "R10", "enabled row", int'(out_en), 15);
        out_req = 4'b0101;
        #1;
        chk(out_en == 4'b0101, "R10", "req pattern", int'(out_en), 5);
        out_req = 4'hF;
    endtask

    task automatic t_oe();
        pdn_mode = 1; oe_pin = 0;
        #1;
        chk(out_en == 4'h0, "R8", "out_en shutdown", int'(out_en), 0);
        chk(pll_run == 1'b0, "R8", "pll_run shutdown", int'(pll_run), 0);
        chk(pll1_en == 1'b0, "R8", "pll1_en shutdown", int'(pll1_en), 0);
        pdn_mode = 0;
        #1;
        chk(out_en == 4'h0, "R9", "out_en oe-low", int'(out_en), 0);
        chk(pll_run == 1'b1, "R9", "pll_run oe-low", int'(pll_run), 1);
        chk(pll1_en == 1'b1, "R9", "pll1_en oe-low", int'(pll1_en), 1);
        sel_s2 = 0;
        tick();
        chk(pll1_en == 1'b0, "R9", "pll1_en follows row", int'(pll1_en), 0);
        pdn_mode = 1; oe_pin = 1; sel_s2 = 1;
        tick();
        chk(out_en == 4'hF, "R8", "out_en running", int'(out_en), 15);
        chk(pll_run == 1'b1, "R8", "pll_run running", int'(pll_run), 1);
    endtask

    initial begin
        fill_expect();
        t_reset();
        t_load();
        t_hold();
        t_ignore();
        t_relatch();
        t_gate();
        t_oe();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule